// File: doc/BRIEF.md
# Task Descriptor Queue Sequencer

This block decides which task a memory-based video engine runs next. Software schedules a task by writing the base address of its descriptor to an enqueue port. The address goes into a four-entry first-in first-out queue. When the sequencer is idle and the queue holds an address, it pops the oldest one and starts the engine on it. After the engine reports done, the sequencer reads the descriptor's link word from memory. That word is at a fixed offset (`LINK_OFS`, 4 by default) from the descriptor base. A nonzero link starts the linked sub-task at once. A zero link ends the chain, and the sequencer then returns to the queue.

Three sticky interrupt bits tell software how the queue stands. One says every queued task has finished. One says a slot has come free. One says a write was lost because the queue was full. Each bit has its own enable. Status outputs give the fill level, a busy flag and the descriptor address currently executing.

Top module: `task_queue_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fill_level` is 0. In that same window `busy`, `irq`, `irq_status`, `eng_start` and `mem_req` are all 0.
- R2: An enqueue write (`enq_valid` high) is accepted when fewer than 4 addresses are held. `fill_level` reports the number held, from 0 to 4, and is never above 4.
- R3: An enqueue write made while 4 addresses are held is dropped, even if a pop happens in the same cycle. The drop sets sticky status bit 2 (overflow) on the next cycle.
- R4: Queued tasks start in the order they were written. Each start is a single-cycle `eng_start` pulse with `eng_desc` equal to the descriptor address. `cur_desc` shows that address, and `busy` is high from the pop until the chain ends.
- R5: After `eng_done`, the sequencer raises `mem_req` with `mem_addr` = current descriptor + 4. It holds `mem_req` and the address stable until `mem_rvalid`, and it never requests memory in a cycle where `eng_start` is high.
- R6: A nonzero link word returned on `mem_rdata` is started next as a sub-task, before any further queued entry. A link word of zero ends the chain.
- R7: When a chain ends while the queue is empty, status bit 0 (all tasks done) is set.
- R8: Every pop from the queue sets status bit 1 (slot freed).
- R9: When `irq_clr_valid` is high, each status bit whose `irq_clr_mask` bit is 1 is cleared. Bits whose mask bit is 0 are left unchanged.
- R10: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue register write strobe |
| enq_addr | input | AW | Descriptor base address to schedule |
| irq_clr_valid | input | 1 | Status clear write strobe |
| irq_clr_mask | input | 3 | Write-one-to-clear mask for status bits |
| irq_en | input | 3 | Per-bit interrupt enable |
| mem_req | output | 1 | Link-word read request |
| mem_addr | output | AW | Link-word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | AW | Link word read from memory |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_desc | output | AW | Descriptor address for the engine |
| eng_done | input | 1 | Engine finished the current descriptor |
| irq | output | 1 | Interrupt request |
| irq_status | output | 3 | Sticky status: bit0 all done, bit1 slot freed, bit2 overflow |
| fill_level | output | $clog2(DEPTH+1) | Addresses held in the queue |
| busy | output | 1 | A task chain is in progress |
| cur_desc | output | AW | Descriptor currently executing |

## Verification
The properties take several things for granted about the neighbours:
- The engine raises `eng_done` only after it has seen a start and while that descriptor is running.
- Memory returns `mem_rvalid` only in answer to an outstanding request.
- Descriptor base addresses are nonzero.

The bench keeps to these rules through its models. The engine model pulses done a fixed number of cycles after each observed start, or later while a stall flag holds it back. The memory model answers only a request that has stayed up for two cycles, so the hold rule is exercised. The memory model looks up link words in a table of chains the bench built itself, and every address it schedules is nonzero.

// File: rtl/tqs_pkg.sv
package tqs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_FETCH
    } seq_state_t;

    localparam int IRQ_N       = 3;
    localparam int IRQ_DRAINED = 0;
    localparam int IRQ_SLOT    = 1;
    localparam int IRQ_OVF     = 2;

    typedef struct packed {
        logic ovf;
        logic slot;
        logic drained;
    } irq_vec_t;

    function automatic logic [IRQ_N-1:0] sticky_next(
        input logic [IRQ_N-1:0] cur,
        input logic [IRQ_N-1:0] set,
        input logic             clr_v,
        input logic [IRQ_N-1:0] clr
    );
        logic [IRQ_N-1:0] kept;
        kept = clr_v ? (cur & ~clr) : cur;
        return kept | set;
    endfunction

endpackage

// File: rtl/tqs_fifo.sv
module tqs_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slots[gi] <= '0;
                else if (push_ok && wr_ptr == PTR_W'(gi))
                    slots[gi] <= push_data;
            end
        end
    endgenerate

endmodule

// File: rtl/tqs_ctrl.sv
module tqs_ctrl
    import tqs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LINK_OFS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_empty,
    input  logic [AW-1:0] q_head,
    output logic          pop,
    output logic          eng_start,
    output logic [AW-1:0] eng_desc,
    input  logic          eng_done,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          chain_end,
    output logic [AW-1:0] cur_desc
);
    seq_state_t    state;
    logic [AW-1:0] cur;
    logic          link_zero;

    assign link_zero = (mem_rdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!q_empty) begin
                        cur   <= q_head;
                        state <= ST_START;
                    end
                end
                ST_START: state <= ST_WAIT;
                ST_WAIT: begin
                    if (eng_done) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        if (link_zero) begin
                            state <= ST_IDLE;
                        end else begin
                            cur   <= mem_rdata;
                            state <= ST_START;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pop       = (state == ST_IDLE) && !q_empty;
        eng_start = (state == ST_START);
        eng_desc  = cur;
        mem_req   = (state == ST_FETCH);
        mem_addr  = cur + AW'(LINK_OFS);
        busy      = (state != ST_IDLE);
        chain_end = (state == ST_FETCH) && mem_rvalid && link_zero;
        cur_desc  = cur;
    end

endmodule

// File: rtl/tqs_irq.sv
module tqs_irq
    import tqs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         set_ev,
    input  logic             clr_valid,
    input  logic [IRQ_N-1:0] clr_mask,
    input  logic [IRQ_N-1:0] en,
    output logic [IRQ_N-1:0] status,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= sticky_next(status, set_ev, clr_valid, clr_mask);
    end

    assign irq = |(status & en);

endmodule

// File: rtl/task_queue_seq.sv
module task_queue_seq
    import tqs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DEPTH    = 4,
    parameter int LINK_OFS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enq_valid,
    input  logic [AW-1:0]              enq_addr,
    input  logic                       irq_clr_valid,
    input  logic [2:0]                 irq_clr_mask,
    input  logic [2:0]                 irq_en,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    input  logic                       mem_rvalid,
    input  logic [AW-1:0]              mem_rdata,
    output logic                       eng_start,
    output logic [AW-1:0]              eng_desc,
    input  logic                       eng_done,
    output logic                       irq,
    output logic [2:0]                 irq_status,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       busy,
    output logic [AW-1:0]              cur_desc
);
    logic          q_full, q_empty, q_pop, chain_end;
    logic [AW-1:0] q_head;
    irq_vec_t      events;

    tqs_fifo #(.DEPTH(DEPTH), .W(AW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (enq_valid),
        .push_data (enq_addr),
        .pop       (q_pop),
        .head      (q_head),
        .count     (fill_level),
        .full      (q_full),
        .empty     (q_empty)
    );

    tqs_ctrl #(.AW(AW), .LINK_OFS(LINK_OFS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .q_empty    (q_empty),
        .q_head     (q_head),
        .pop        (q_pop),
        .eng_start  (eng_start),
        .eng_desc   (eng_desc),
        .eng_done   (eng_done),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .chain_end  (chain_end),
        .cur_desc   (cur_desc)
    );

    always_comb begin
        events.drained = chain_end && q_empty;
        events.slot    = q_pop;
        events.ovf     = enq_valid && q_full;
    end

    tqs_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_ev    (events),
        .clr_valid (irq_clr_valid),
        .clr_mask  (irq_clr_mask),
        .en        (irq_en),
        .status    (irq_status),
        .irq       (irq)
    );

endmodule

// File: rtl/tqs_checker.sv
module tqs_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       enq_valid,
    input logic                       mem_req,
    input logic [AW-1:0]              mem_addr,
    input logic                       mem_rvalid,
    input logic                       eng_start,
    input logic                       busy,
    input logic [2:0]                 irq_status,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // R2: fill level never exceeds the queue depth
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_level <= CNT_W'(DEPTH));

    // R3: a write into a full queue raises the overflow bit
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && fill_level == CNT_W'(DEPTH)) |=> irq_status[2]);

    // R4: start is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R4: busy is high whenever a start is issued
    a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    // R5: request and address held until data returns
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R5: no memory request alongside a start
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !mem_req);

endmodule

bind task_queue_seq tqs_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_valid  (enq_valid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .eng_start  (eng_start),
    .busy       (busy),
    .irq_status (irq_status),
    .fill_level (fill_level)
);

// File: tb/sim_task_queue_seq.sv
`timescale 1ns/1ps
module sim_task_queue_seq;
    localparam int AW  = 32;
    localparam int DEP = 4;
    localparam int OFS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [AW-1:0] enq_addr = '0;
    logic          irq_clr_valid = 1'b0;
    logic [2:0]    irq_clr_mask = '0;
    logic [2:0]    irq_en = 3'b111;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [AW-1:0] mem_rdata = '0;
    logic          eng_start;
    logic [AW-1:0] eng_desc;
    logic          eng_done = 1'b0;
    logic          irq;
    logic [2:0]    irq_status;
    logic [2:0]    fill_level;
    logic          busy;
    logic [AW-1:0] cur_desc;

    always #2 clk = ~clk;

    task_queue_seq #(.AW(AW), .DEPTH(DEP), .LINK_OFS(OFS)) u0 (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_addr(enq_addr),
        .irq_clr_valid(irq_clr_valid), .irq_clr_mask(irq_clr_mask), .irq_en(irq_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_desc(eng_desc),
        .eng_done(eng_done), .irq(irq), .irq_status(irq_status),
        .fill_level(fill_level), .busy(busy), .cur_desc(cur_desc)
    );

    logic [AW-1:0] link_mem [logic [AW-1:0]];
    logic [AW-1:0] exp_q [$];
    logic [AW-1:0] last_start = '0;
    int  checks = 0;
    int  errors = 0;
    bit  stall = 1'b0;
    int  pend_cnt = 0;
    bit  pend = 1'b0;
    int  mwait = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] link_of(input logic [AW-1:0] a);
        return link_mem.exists(a + OFS) ? link_mem[a + OFS] : '0;
    endfunction

    // driver: writes the enqueue register, pushes the expected chain
    task automatic enq(input logic [AW-1:0] base, input bit accept);
        logic [AW-1:0] a;
        enq_valid = 1'b1;
        enq_addr  = base;
        if (accept) begin
            a = base;
            while (a != '0) begin
                exp_q.push_back(a);
                a = link_of(a);
            end
        end
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic clr(input logic [2:0] m);
        irq_clr_valid = 1'b1;
        irq_clr_mask  = m;
        @(negedge clk);
        irq_clr_valid = 1'b0;
        irq_clr_mask  = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy && fill_level == 0 && exp_q.size() == 0) break;
            @(negedge clk);
        end
    endtask

    // monitor, engine model and memory model
    initial forever begin
        @(negedge clk);
        eng_done = 1'b0;
        if (pend && !stall) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                eng_done = 1'b1;
                pend     = 1'b0;
            end
        end
        if (!rst && eng_start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected start", eng_desc, '0);
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                chk(eng_desc == e, "R6", "start order", eng_desc, e);
            end
            chk(cur_desc == eng_desc, "R4", "cur_desc at start", cur_desc, eng_desc);
            chk(busy, "R4", "busy at start", AW'(busy), 1);
            last_start = eng_desc;
            pend       = 1'b1;
            pend_cnt   = 2;
        end
        mem_rvalid = 1'b0;
        if (!rst && mem_req) begin
            mwait++;
            if (mwait >= 2) begin
                chk(mem_addr == last_start + OFS, "R5", "link address",
                    mem_addr, last_start + OFS);
                mem_rvalid = 1'b1;
                mem_rdata  = link_mem.exists(mem_addr) ? link_mem[mem_addr] : '0;
                mwait      = 0;
            end
        end else begin
            mwait = 0;
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // chains
        link_mem[32'h100 + OFS] = '0;
        link_mem[32'h200 + OFS] = 32'h240;
        link_mem[32'h240 + OFS] = 32'h280;
        link_mem[32'h280 + OFS] = '0;
        link_mem[32'h400 + OFS] = 32'h440;
        link_mem[32'h600 + OFS] = 32'h640;

        repeat (3) @(negedge clk);
        chk(fill_level == 0 && !busy, "R1", "reset fill/busy", AW'({fill_level, busy}), 0);
        chk(irq_status == 0 && !irq, "R1", "reset status/irq", AW'({irq_status, irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!eng_start && !mem_req && !busy, "R1", "idle after reset",
            AW'({eng_start, mem_req, busy}), 0);

        // single task without sub-tasks
        enq(32'h100, 1'b1);
        chk(fill_level == 1, "R2", "fill after one write", AW'(fill_level), 1);
        wait_idle();
        chk(irq_status[0], "R7", "all-done bit", AW'(irq_status), 3'b011);
        chk(irq_status[1], "R8", "slot-freed bit", AW'(irq_status), 3'b011);
        chk(irq, "R10", "irq enabled", AW'(irq), 1);

        // write-one-to-clear
        clr(3'b001);
        chk(irq_status == 3'b010, "R9", "clear bit0 only", AW'(irq_status), 3'b010);
        clr(3'b010);
        chk(irq_status == 3'b000, "R9", "clear bit1", AW'(irq_status), 0);
        chk(!irq, "R10", "irq low when no status", AW'(irq), 0);

        // chained task followed by a plain task
        enq(32'h200, 1'b1);
        enq(32'h300, 1'b1);
        wait_idle();
        chk(exp_q.size() == 0, "R6", "chain fully run", exp_q.size(), 0);
        chk(irq_status[0], "R7", "all-done after chain", AW'(irq_status), 3'b011);
        clr(3'b111);

        // fill the queue with the engine stalled
        stall = 1'b1;
        enq(32'h400, 1'b1);
        repeat (4) @(negedge clk);
        chk(fill_level == 0 && busy, "R4", "first task popped",
            AW'({fill_level, busy}), 1);
        chk(cur_desc == 32'h400, "R4", "cur_desc while running", cur_desc, 32'h400);
        enq(32'h500, 1'b1);
        chk(fill_level == 1, "R2", "fill 1", AW'(fill_level), 1);
        enq(32'h600, 1'b1);
        enq(32'h700, 1'b1);
        enq(32'h800, 1'b1);
        chk(fill_level == 4, "R2", "fill 4", AW'(fill_level), 4);
        chk(!irq_status[2], "R3", "no overflow yet", AW'(irq_status), 0);
        enq(32'h900, 1'b0);
        chk(fill_level == 4, "R3", "full write dropped", AW'(fill_level), 4);
        chk(irq_status[2], "R3", "overflow bit", AW'(irq_status), 3'b110);

        // masking
        irq_en = 3'b000;
        @(negedge clk);
        chk(!irq, "R10", "all masked", AW'(irq), 0);
        irq_en = 3'b100;
        @(negedge clk);
        chk(irq, "R10", "overflow enabled", AW'(irq), 1);
        irq_en = 3'b001;
        @(negedge clk);
        chk(!irq, "R10", "only all-done enabled", AW'(irq), 0);
        irq_en = 3'b111;

        stall = 1'b0;
        wait_idle();
        @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all queued tasks ran", exp_q.size(), 0);
        chk(fill_level == 0 && !busy, "R2", "drained", AW'({fill_level, busy}), 0);
        chk(irq_status == 3'b111, "R7", "status after drain", AW'(irq_status), 3'b111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule